// File: doc/BRIEF.md
# Speculative Load Poison Tracker

This block keeps one pending flag and one poison flag for every architectural register that a speculative load can target. When a speculative load is issued, its destination becomes pending. When the load returns, the pending flag clears. If the load failed, no fault is raised at that moment. Instead, the destination is marked poisoned, and the fault is carried forward in that flag.

Consumers query the tracker through a single request port. A request is either a check or a plain read. A check on a pending register stalls the requester for as long as the load is outstanding. A check on a register that holds good data completes with no effect. A check or a read that finds the register poisoned raises the deferred exception and names the register. A poisoned register that is never consumed never raises anything. A non-speculative write to a register repairs it, which clears both of its flags.

Top module: `spec_poison_tracker`

## Requirements
- R1: After reset every register is neither pending nor poisoned, `stall` is low and `exc_valid` is low.
- R2: An issue (`iss_valid`) to register r makes r pending and clears its poison flag. The new state is visible to requests from the next cycle.
- R3: A completion (`cmp_valid`) with `cmp_fault`=0 on a pending register clears its pending flag. A later check on that register does not stall and raises no exception.
- R4: A completion with `cmp_fault`=1 on a pending register raises no exception in any cycle. It clears the pending flag and poisons the register.
- R5: `stall` is combinational. It is high in exactly the cycles where `req_valid`=1, `req_is_check`=1 (1 means check, 0 means read) and the requested register is pending.
- R6: A request of either kind whose register is poisoned drives `exc_valid` high in the following cycle, with `exc_reg` equal to that register. Each such request cycle produces exactly one pulse.
- R7: A read (`req_is_check`=0) never stalls, even when its register is pending.
- R8: A poisoned register that receives no request causes no exception. Requests to other registers produce none either.
- R9: A non-speculative write (`wr_valid`) to register r clears both its pending and poison flags.
- R10: A completion on a register that is not pending has no effect. In particular, a late faulting completion after a write does not poison the register.
- R11: When several update ports name the same register in one cycle, the write has priority over the issue, and the issue has priority over the completion. A request in that cycle sees the state from before the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Speculative load issued |
| iss_reg | input | IDX_W | Destination of the issued load |
| cmp_valid | input | 1 | Speculative load returned |
| cmp_reg | input | IDX_W | Destination of the returned load |
| cmp_fault | input | 1 | The returned load failed |
| wr_valid | input | 1 | Non-speculative register write |
| wr_reg | input | IDX_W | Register written |
| req_valid | input | 1 | Check or read request |
| req_is_check | input | 1 | 1 = check, 0 = read |
| req_reg | input | IDX_W | Register requested |
| stall | output | 1 | Check must wait for an outstanding load |
| exc_valid | output | 1 | Deferred exception pulse |
| exc_reg | output | IDX_W | Register that raised the exception (0 when idle) |

## Verification
The hardest case to reach is a collision. This happens when an issue, a completion and a write hit one register in the same cycle while a request reads it, or when a faulting completion arrives after a write has already repaired the register. The random stimulus draws every register index from a pool of eight low registers plus the highest one, so collisions happen often. Directed sequences then force the late-fault, stall-then-resolve and unused-poison orderings explicitly.

// File: rtl/ptrk_pkg.sv
package ptrk_pkg;
    typedef enum logic {
        REQ_READ  = 1'b0,
        REQ_CHECK = 1'b1
    } req_kind_e;
endpackage

// File: rtl/ptrk_state.sv
module ptrk_state #(
    parameter int NUM_REGS = 128,
    parameter int IDX_W    = $clog2(NUM_REGS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                iss_valid,
    input  logic [IDX_W-1:0]    iss_reg,
    input  logic                cmp_valid,
    input  logic [IDX_W-1:0]    cmp_reg,
    input  logic                cmp_fault,
    input  logic                wr_valid,
    input  logic [IDX_W-1:0]    wr_reg,
    output logic [NUM_REGS-1:0] pend_q,
    output logic [NUM_REGS-1:0] pois_q
);
    typedef struct packed {
        logic [NUM_REGS-1:0] pend;
        logic [NUM_REGS-1:0] pois;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (wr_valid && wr_reg == IDX_W'(i)) begin
                st_d.pend[i] = 1'b0;
                st_d.pois[i] = 1'b0;
            end else if (iss_valid && iss_reg == IDX_W'(i)) begin
                st_d.pend[i] = 1'b1;
                st_d.pois[i] = 1'b0;
            end else if (cmp_valid && cmp_reg == IDX_W'(i) && st_q.pend[i]) begin
                st_d.pend[i] = 1'b0;
                st_d.pois[i] = cmp_fault;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_q = st_q.pend;
    assign pois_q = st_q.pois;

    assert_issue_sets_pending_R2: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid && !(wr_valid && wr_reg == iss_reg)
        |=> pend_q[$past(iss_reg)] && !pois_q[$past(iss_reg)]);

    assert_write_repairs_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> !pend_q[$past(wr_reg)] && !pois_q[$past(wr_reg)]);

    assert_stale_completion_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_valid && !pend_q[cmp_reg]
        && !(wr_valid && wr_reg == cmp_reg) && !(iss_valid && iss_reg == cmp_reg)
        |=> pois_q[$past(cmp_reg)] == $past(pois_q[cmp_reg]) && !pend_q[$past(cmp_reg)]);

    assert_fault_poisons_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_valid && cmp_fault && pend_q[cmp_reg]
        && !(wr_valid && wr_reg == cmp_reg) && !(iss_valid && iss_reg == cmp_reg)
        |=> pois_q[$past(cmp_reg)] && !pend_q[$past(cmp_reg)]);
endmodule

// File: rtl/ptrk_resolver.sv
module ptrk_resolver
    import ptrk_pkg::*;
#(
    parameter int NUM_REGS = 128,
    parameter int IDX_W    = $clog2(NUM_REGS)
) (
    input  logic                req_valid,
    input  req_kind_e           req_kind,
    input  logic [IDX_W-1:0]    req_reg,
    input  logic [NUM_REGS-1:0] pend_q,
    input  logic [NUM_REGS-1:0] pois_q,
    output logic                stall,
    output logic                hit_poison
);
    logic sel_pend, sel_pois;

    always_comb begin
        sel_pend   = pend_q[req_reg];
        sel_pois   = pois_q[req_reg];
        stall      = req_valid && (req_kind == REQ_CHECK) && sel_pend;
        hit_poison = req_valid && sel_pois;
    end

    always_comb begin
        assert_read_never_stalls_R7: assert (!(req_valid && req_kind == REQ_READ && stall));
        assert_flags_exclusive_R2: assert (!(sel_pend && sel_pois));
    end
endmodule

// File: rtl/spec_poison_tracker.sv
module spec_poison_tracker
    import ptrk_pkg::*;
#(
    parameter int NUM_REGS = 128,
    parameter int IDX_W    = $clog2(NUM_REGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             iss_valid,
    input  logic [IDX_W-1:0] iss_reg,
    input  logic             cmp_valid,
    input  logic [IDX_W-1:0] cmp_reg,
    input  logic             cmp_fault,
    input  logic             wr_valid,
    input  logic [IDX_W-1:0] wr_reg,
    input  logic             req_valid,
    input  logic             req_is_check,
    input  logic [IDX_W-1:0] req_reg,
    output logic             stall,
    output logic             exc_valid,
    output logic [IDX_W-1:0] exc_reg
);
    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] idx;
    } exc_t;

    logic [NUM_REGS-1:0] pend_q, pois_q;
    logic                hit_poison;
    req_kind_e           req_kind;
    exc_t                exc_d, exc_q;

    assign req_kind = req_is_check ? REQ_CHECK : REQ_READ;

    ptrk_state #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_state (
        .clk(clk), .rst_n(rst_n),
        .iss_valid(iss_valid), .iss_reg(iss_reg),
        .cmp_valid(cmp_valid), .cmp_reg(cmp_reg), .cmp_fault(cmp_fault),
        .wr_valid(wr_valid), .wr_reg(wr_reg),
        .pend_q(pend_q), .pois_q(pois_q)
    );

    ptrk_resolver #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_resolver (
        .req_valid(req_valid), .req_kind(req_kind), .req_reg(req_reg),
        .pend_q(pend_q), .pois_q(pois_q),
        .stall(stall), .hit_poison(hit_poison)
    );

    always_comb begin
        exc_d.valid = hit_poison;
        exc_d.idx   = hit_poison ? req_reg : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) exc_q <= '0;
        else        exc_q <= exc_d;
    end

    assign exc_valid = exc_q.valid;
    assign exc_reg   = exc_q.idx;

    assert_exc_from_poisoned_use_R6: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |-> $past(req_valid) && $past(pois_q[req_reg]) && exc_reg == $past(req_reg));

    assert_clean_use_no_exc_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && pois_q[req_reg]) |=> !exc_valid);

    assert_stall_only_on_check_R5: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> req_valid && req_is_check && pend_q[req_reg]);

    assert_fault_not_immediate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_valid && cmp_fault && !req_valid |=> !exc_valid);
endmodule

// File: tb/spec_poison_tracker_bench.sv
module spec_poison_tracker_bench;
    localparam int N  = 128;
    localparam int IW = $clog2(N);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic iss_valid = 0, cmp_valid = 0, cmp_fault = 0, wr_valid = 0, req_valid = 0, req_is_check = 0;
    logic [IW-1:0] iss_reg = '0, cmp_reg = '0, wr_reg = '0, req_reg = '0;
    logic stall, exc_valid;
    logic [IW-1:0] exc_reg;

    always #4 clk = ~clk;

    spec_poison_tracker #(.NUM_REGS(N)) u_spec_poison_tracker (
        .clk(clk), .rst_n(rst_n),
        .iss_valid(iss_valid), .iss_reg(iss_reg),
        .cmp_valid(cmp_valid), .cmp_reg(cmp_reg), .cmp_fault(cmp_fault),
        .wr_valid(wr_valid), .wr_reg(wr_reg),
        .req_valid(req_valid), .req_is_check(req_is_check), .req_reg(req_reg),
        .stall(stall), .exc_valid(exc_valid), .exc_reg(exc_reg)
    );

    int checks = 0, errors = 0;
    bit done = 0;
    bit pend_m [N];
    bit pois_m [N];
    bit exp_exc = 0;
    logic [IW-1:0] exp_exc_reg = '0;

    function automatic bit pred_stall(bit rv, bit rk, int r);
        return rv && rk && pend_m[r];
    endfunction

    function automatic bit pred_exc(bit rv, int r);
        return rv && pois_m[r];
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(bit iv, int ir, bit cv, int cr, bit cf, bit wv, int wr,
                        bit rv, bit rk, int rr, string tag);
        bit cmp_hit;
        @(negedge clk);
        check(exc_valid == exp_exc, {tag, " R6/R8 exc_valid"}, exc_valid, exp_exc);
        if (exp_exc) check(exc_reg == exp_exc_reg, {tag, " R6 exc_reg"}, exc_reg, exp_exc_reg);
        iss_valid = iv; iss_reg = IW'(ir);
        cmp_valid = cv; cmp_reg = IW'(cr); cmp_fault = cf;
        wr_valid = wv; wr_reg = IW'(wr);
        req_valid = rv; req_is_check = rk; req_reg = IW'(rr);
        #1;
        check(stall == pred_stall(rv, rk, rr), {tag, " R5/R7 stall"}, stall, pred_stall(rv, rk, rr));
        exp_exc = pred_exc(rv, rr);
        exp_exc_reg = IW'(rr);
        cmp_hit = cv && pend_m[cr];
        if (cmp_hit) begin pend_m[cr] = 0; pois_m[cr] = cf; end
        if (iv) begin pend_m[ir] = 1; pois_m[ir] = 0; end
        if (wv) begin pend_m[wr] = 0; pois_m[wr] = 0; end
    endtask

    task automatic idle_req(bit rv, bit rk, int rr, string tag);
        step(0, 0, 0, 0, 0, 0, 0, rv, rk, rr, tag);
    endtask

    function automatic int pick();
        int v = int'($urandom_range(0, 8));
        return (v == 8) ? N - 1 : v;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < N; i++) begin pend_m[i] = 0; pois_m[i] = 0; end
        repeat (3) @(posedge clk);
        #1;
        check(stall == 0 && exc_valid == 0, "R1 reset outputs", {stall, exc_valid}, 0);
        @(negedge clk); rst_n = 1;

        // R1: all registers clean after reset
        idle_req(1, 1, 0, "R1");
        idle_req(1, 1, N - 1, "R1");
        idle_req(1, 0, 3, "R1");

        // R2, R5, R7: pending register stalls a check but not a read
        step(1, 4, 0, 0, 0, 0, 0, 1, 1, 4, "R11 req sees old state");
        idle_req(1, 1, 4, "R2 R5");
        idle_req(1, 0, 4, "R7");
        // R3: good completion, then check is a no-op
        step(0, 0, 1, 4, 0, 0, 0, 1, 1, 4, "R5");
        idle_req(1, 1, 4, "R3");

        // R4, R8: faulting load, no exception until use
        step(1, N - 1, 0, 0, 0, 0, 0, 0, 0, 0, "R2");
        step(0, 0, 1, N - 1, 1, 0, 0, 0, 0, 0, "R4");
        for (int k = 0; k < 6; k++) idle_req(1, k[0], k, "R8");
        idle_req(1, 1, N - 1, "R6 check");
        idle_req(1, 0, N - 1, "R6 read");
        idle_req(0, 0, 0, "R6 pulse end");
        // R9: write repairs
        step(0, 0, 0, 0, 0, 1, N - 1, 0, 0, 0, "R9");
        idle_req(1, 1, N - 1, "R9");
        idle_req(0, 0, 0, "R9");

        // R10: late faulting completion after write
        step(1, 6, 0, 0, 0, 0, 0, 0, 0, 0, "R10");
        step(0, 0, 0, 0, 0, 1, 6, 0, 0, 0, "R10");
        step(0, 0, 1, 6, 1, 0, 0, 0, 0, 0, "R10");
        idle_req(1, 1, 6, "R10");
        idle_req(1, 0, 6, "R10");

        // R11: collisions on one register
        step(1, 2, 0, 0, 0, 1, 2, 0, 0, 0, "R11 write beats issue");
        idle_req(1, 1, 2, "R11");
        step(1, 2, 0, 0, 0, 0, 0, 0, 0, 0, "R11");
        step(1, 2, 1, 2, 1, 0, 0, 0, 0, 0, "R11 issue beats completion");
        idle_req(1, 1, 2, "R11");
        idle_req(1, 0, 2, "R11");

        // random traffic over a small register pool
        for (int n = 0; n < 3000; n++) begin
            step($urandom_range(0, 3) == 0, pick(),
                 $urandom_range(0, 2) == 0, pick(), $urandom_range(0, 1) == 1,
                 $urandom_range(0, 7) == 0, pick(),
                 $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1, pick(), "R11 random");
        end
        idle_req(0, 0, 0, "final");
        idle_req(0, 0, 0, "final");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule